// File: doc/BRIEF.md
# Delayed-Branch Fetch Controller

This block steers instruction fetch for a three-stage pipeline (fetch, decode, execute) that runs unconditional branches with one delay slot. Each slot it issues a halfword fetch address and takes back the 16-bit word fetched there in the same cycle. It decodes that word in the decode stage and moves it to execute. When an unconditional branch reaches execute, the block computes the target there, asks the register file for the operand it needs, and redirects fetch. The word that follows the branch is never discarded. It waits one extra cycle in decode and then executes normally.

A three-state machine controls the sequencing. ST_RUN is plain sequential fetch. ST_SLOT is the slot in which a branch sits in execute: the redirect and the decode stall are raised and no fetch is issued. ST_TARGET is the slot in which the target is fetched while the delay-slot word finishes its second decode cycle. The transitions are:
- run-to-slot: a legal branch leaves decode.
- slot-to-target: always.
- target-to-run: always, because decode then holds the delay-slot word, which cannot start a redirect.
- run-to-run: no legal branch leaves decode.

Subroutine-call forms produce a return address in execute. A branch found in a delay slot is reported and is not taken.

Top module: `dbr_fetch_ctl`

## Requirements
- R1: While `rst` is high, all three stage valid flags, `fetch_req`, `id_stall` and `redirect` are low. In the first cycle after `rst` falls, `fetch_addr` equals the `reset_vec` value sampled at the last reset edge, and `fetch_req` is high.
- R2: Outside the redirect slot, `fetch_req` is high every cycle. After a fetch that was not followed by a redirect, the next `fetch_addr` is the previous one plus 2.
- R3: `redirect` is high in exactly one cycle per legal branch. That cycle comes two cycles after the branch word was fetched, when the branch is in execute. In that cycle `fetch_req` is low.
- R4: In the redirect cycle `id_valid` is high, because the delay-slot word is held in decode. In the next cycle `ex_valid` is low (a bubble). In the cycle after that, `ex_valid` is high, because the delay-slot word executes.
- R5: `id_stall` is high in the redirect cycle and in no other cycle.
- R6: In the cycle after a redirect, `fetch_req` is high and `fetch_addr` equals the `redirect_addr` given in the redirect cycle.
- R7: A word with bits [15:12] = 4'hA (jump) or 4'hB (call) is PC-relative. Its target is the branch address + 4 + 2 × (bits [11:0] as a signed number).
- R8: A word with bits [15:12] = 4'h8 and bits [7:4] = 0 is a register branch. It names register index bits [11:8] on `reg_idx` while in execute. Bits [3:0] = 0 (jump) or 1 (call) give the target branch address + 4 + `reg_val`.
- R9: In the same register class, bits [3:0] = 2 (jump), 3 (call) or 4 (return) give the target `reg_val`. Any other low nibble, or any other top nibble, is not a branch.
- R10: Bit 0 of `redirect_addr` is always 0.
- R11: For the call forms (4'hB, and sub-codes 1 and 3), `link_valid` is high in the redirect cycle and `link_addr` = branch address + 4. `link_valid` is never high outside a redirect cycle, and it is low for jumps and returns.
- R12: A branch word that sits in the delay slot of a legal branch raises `illegal_slot` for one cycle while it is in execute. No redirect and no link strobe occur in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reset_vec | input | ADDR_W | Fetch start address loaded during reset |
| instr | input | 16 | Word fetched at `fetch_addr` in the same cycle |
| reg_val | input | ADDR_W | Register-file value for `reg_idx` |
| fetch_addr | output | ADDR_W | Instruction fetch address |
| fetch_req | output | 1 | Fetch request for this cycle |
| if_valid | output | 1 | Fetch stage holds a valid word |
| id_valid | output | 1 | Decode stage holds a valid word |
| ex_valid | output | 1 | Execute stage holds a valid word |
| id_stall | output | 1 | Decode stage is stalled this cycle |
| reg_idx | output | RIDX_W | Register index wanted by the word in execute |
| redirect | output | 1 | Branch taken; fetch moves to `redirect_addr` next cycle |
| redirect_addr | output | ADDR_W | Branch target, halfword aligned |
| link_valid | output | 1 | Return address is valid (call forms) |
| link_addr | output | ADDR_W | Return address |
| illegal_slot | output | 1 | Branch found in a delay slot |

## Verification
The bench builds the block with the default 32-bit address, 12-bit displacement and 4-bit register index. A 32-bit address makes the full sign extension of a negative displacement and the add of a wide register value visible. The test program drives every target mode, including a backward displacement and a register value with bit 0 set. It also places a branch inside a delay slot, so that the slot hold, the bubble and the illegal-slot case all occur together with a following legal branch. A second reset in the middle of the run, with a new start address, checks that the pipeline clears and restarts.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int INSTR_W = 16;

    // Branch classes resolved in decode and carried to execute
    typedef enum logic [2:0] {
        K_NONE,
        K_REL_JMP,
        K_REL_CALL,
        K_PCR_JMP,
        K_PCR_CALL,
        K_ABS_JMP,
        K_ABS_CALL,
        K_RET
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SLOT   = 2'd1,
        ST_TARGET = 2'd2
    } fstate_e;

    localparam logic [3:0] OPC_REL_JMP  = 4'hA;
    localparam logic [3:0] OPC_REL_CALL = 4'hB;
    localparam logic [3:0] OPC_REG      = 4'h8;

    function automatic logic kind_is_call(br_kind_e k);
        return (k == K_REL_CALL) || (k == K_PCR_CALL) || (k == K_ABS_CALL);
    endfunction

endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter int DISP_W = 12,
    parameter int RIDX_W = 4
) (
    input  logic [INSTR_W-1:0] word,
    output br_kind_e           kind,
    output logic [DISP_W-1:0]  disp,
    output logic [RIDX_W-1:0]  ridx
);

    localparam int OPC_W  = INSTR_W - DISP_W;
    localparam int SUB_W  = 4;
    localparam int FILL_W = DISP_W - RIDX_W - SUB_W;

    logic [OPC_W-1:0]  opc;
    logic [FILL_W-1:0] fill;
    logic [SUB_W-1:0]  sub;

    assign opc  = word[INSTR_W-1 -: OPC_W];
    assign disp = word[DISP_W-1:0];
    assign ridx = word[DISP_W-1 -: RIDX_W];
    assign fill = word[SUB_W +: FILL_W];
    assign sub  = word[SUB_W-1:0];

    always_comb begin
        kind = K_NONE;
        unique case (opc)
            OPC_REL_JMP:  kind = K_REL_JMP;
            OPC_REL_CALL: kind = K_REL_CALL;
            OPC_REG: begin
                if (fill == '0) begin
                    unique case (sub)
                        4'd0:    kind = K_PCR_JMP;
                        4'd1:    kind = K_PCR_CALL;
                        4'd2:    kind = K_ABS_JMP;
                        4'd3:    kind = K_ABS_CALL;
                        4'd4:    kind = K_RET;
                        default: kind = K_NONE;
                    endcase
                end
            end
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/dbr_target.sv
module dbr_target
    import dbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 12
) (
    input  br_kind_e          kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] link
);

    localparam int               EXT_W    = ADDR_W - DISP_W - 1;
    localparam logic [ADDR_W-1:0] SEQ_OFF = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ALIGN   = ~ADDR_W'(1);

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] raw;

    assign seq_pc = pc + SEQ_OFF;
    // signed halfword displacement
    assign offs   = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};

    always_comb begin
        unique case (kind)
            K_REL_JMP, K_REL_CALL:        raw = seq_pc + offs;
            K_PCR_JMP, K_PCR_CALL:        raw = seq_pc + reg_val;
            K_ABS_JMP, K_ABS_CALL, K_RET: raw = reg_val;
            default:                      raw = seq_pc;
        endcase
    end

    assign target = raw & ALIGN;
    assign link   = seq_pc;

endmodule

// File: rtl/dbr_fetch_ctl.sv
module dbr_fetch_ctl
    import dbr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 12,
    parameter int RIDX_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reset_vec,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  reg_val,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               fetch_req,
    output logic               if_valid,
    output logic               id_valid,
    output logic               ex_valid,
    output logic               id_stall,
    output logic [RIDX_W-1:0]  reg_idx,
    output logic               redirect,
    output logic [ADDR_W-1:0]  redirect_addr,
    output logic               link_valid,
    output logic [ADDR_W-1:0]  link_addr,
    output logic               illegal_slot
);

    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(2);

    fstate_e state_q, state_d;

    logic [ADDR_W-1:0]  pc_q;

    logic               id_valid_q;
    logic               id_slot_q;
    logic [INSTR_W-1:0] id_instr_q;
    logic [ADDR_W-1:0]  id_pc_q;

    logic               ex_valid_q;
    logic               ex_slot_q;
    br_kind_e           ex_kind_q;
    logic [DISP_W-1:0]  ex_disp_q;
    logic [RIDX_W-1:0]  ex_ridx_q;
    logic [ADDR_W-1:0]  ex_pc_q;

    br_kind_e           id_kind;
    logic [DISP_W-1:0]  id_disp;
    logic [RIDX_W-1:0]  id_ridx;
    logic               id_takes;
    logic [ADDR_W-1:0]  tgt;
    logic [ADDR_W-1:0]  lnk;

    dbr_decode #(
        .DISP_W (DISP_W),
        .RIDX_W (RIDX_W)
    ) u_dec (
        .word (id_instr_q),
        .kind (id_kind),
        .disp (id_disp),
        .ridx (id_ridx)
    );

    dbr_target #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_tgt (
        .kind    (ex_kind_q),
        .pc      (ex_pc_q),
        .reg_val (reg_val),
        .disp    (ex_disp_q),
        .target  (tgt),
        .link    (lnk)
    );

    // a branch in decode that is not itself in a delay slot
    assign id_takes = id_valid_q && (id_kind != K_NONE) && !id_slot_q;

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_TARGET: state_d = id_takes ? ST_SLOT : ST_RUN;
            ST_SLOT:           state_d = ST_TARGET;
            default:           state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // pipeline registers; ST_SLOT holds decode and injects a bubble into execute
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= reset_vec;
            id_valid_q <= 1'b0;
            id_slot_q  <= 1'b0;
            ex_valid_q <= 1'b0;
            ex_slot_q  <= 1'b0;
        end else if (state_q == ST_SLOT) begin
            pc_q       <= tgt;
            ex_valid_q <= 1'b0;
            ex_slot_q  <= 1'b0;
        end else begin
            pc_q       <= pc_q + HALF_STEP;
            id_valid_q <= 1'b1;
            id_instr_q <= instr;
            id_pc_q    <= pc_q;
            id_slot_q  <= id_takes;
            ex_valid_q <= id_valid_q;
            ex_slot_q  <= id_slot_q;
            ex_kind_q  <= id_kind;
            ex_disp_q  <= id_disp;
            ex_ridx_q  <= id_ridx;
            ex_pc_q    <= id_pc_q;
        end
    end

    always_comb begin
        fetch_req  = 1'b0;
        id_stall   = 1'b0;
        redirect   = 1'b0;
        link_valid = 1'b0;
        if (!rst) begin
            unique case (state_q)
                ST_RUN, ST_TARGET: fetch_req = 1'b1;
                ST_SLOT: begin
                    id_stall   = 1'b1;
                    redirect   = 1'b1;
                    link_valid = kind_is_call(ex_kind_q);
                end
                default: fetch_req = 1'b0;
            endcase
        end
        illegal_slot  = !rst && ex_valid_q && ex_slot_q && (ex_kind_q != K_NONE);
        if_valid      = fetch_req;
        id_valid      = id_valid_q && !rst;
        ex_valid      = ex_valid_q && !rst;
        fetch_addr    = pc_q;
        reg_idx       = ex_ridx_q;
        redirect_addr = tgt;
        link_addr     = lnk;
    end

endmodule

// File: rtl/dbr_fetch_ctl_chk.sv
module dbr_fetch_ctl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reset_vec,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_req,
    input logic              id_valid,
    input logic              id_stall,
    input logic              redirect,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              link_valid,
    input logic              illegal_slot
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    a_r1_restart_vector: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_req && fetch_addr == $past(reset_vec)));

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (rst)
        ($past(fetch_req) && !$past(redirect) && !$past(rst) && fetch_req)
            |-> (fetch_addr == $past(fetch_addr) + STEP));

    a_r3_no_fetch_on_redirect: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !fetch_req);

    a_r4_slot_held: assert property (@(posedge clk) disable iff (rst)
        redirect |-> id_valid);

    a_r5_single_stall: assert property (@(posedge clk) disable iff (rst)
        id_stall |=> !id_stall);

    a_r6_target_fetched: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (fetch_req && fetch_addr == $past(redirect_addr)));

    a_r10_halfword_target: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !redirect_addr[0]);

    a_r11_link_in_redirect: assert property (@(posedge clk) disable iff (rst)
        link_valid |-> redirect);

    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_slot |-> (!redirect && !link_valid));

endmodule

bind dbr_fetch_ctl dbr_fetch_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_dbr_fetch_ctl.sv
module tb_dbr_fetch_ctl;

    localparam int AW = 32;
    localparam int RW = 4;

    typedef struct {
        logic [AW-1:0] br;
        logic [AW-1:0] tgt;
        bit            link;
        logic [AW-1:0] laddr;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reset_vec = 32'h10;
    logic [15:0]   instr;
    logic [AW-1:0] reg_val;
    logic [AW-1:0] fetch_addr;
    logic          fetch_req, if_valid, id_valid, ex_valid, id_stall;
    logic [RW-1:0] reg_idx;
    logic          redirect, link_valid, illegal_slot;
    logic [AW-1:0] redirect_addr, link_addr;

    logic [15:0]   imem [128];
    logic [AW-1:0] regs [16];

    int n_chk  = 0;
    int n_fail = 0;
    int n_red  = 0;
    int n_ill  = 0;
    bit mon_on = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    assign instr   = imem[fetch_addr[7:1]];
    assign reg_val = regs[reg_idx];

    dbr_fetch_ctl dut (
        .clk (clk), .rst (rst), .reset_vec (reset_vec), .instr (instr),
        .reg_val (reg_val), .fetch_addr (fetch_addr), .fetch_req (fetch_req),
        .if_valid (if_valid), .id_valid (id_valid), .ex_valid (ex_valid),
        .id_stall (id_stall), .reg_idx (reg_idx), .redirect (redirect),
        .redirect_addr (redirect_addr), .link_valid (link_valid),
        .link_addr (link_addr), .illegal_slot (illegal_slot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [AW-1:0] br, input logic [AW-1:0] tgt,
                            input bit link, input string tag);
        exp_t e;
        e.br = br; e.tgt = tgt; e.link = link; e.laddr = br + 4; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    logic [AW-1:0] h1 = '0, h2 = '0, pr_raddr = '0, pr_faddr = '0;
    bit pr_red = 0, pr2_red = 0, pr_freq = 0;
    exp_t cur;

    always @(negedge clk) begin
        if (mon_on) begin
            if (redirect) begin
                n_red++;
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected redirect", redirect_addr, '0);
                end else begin
                    cur = exp_q.pop_front();
                    chk(redirect_addr == cur.tgt, cur.tag, "target", redirect_addr, cur.tgt);
                    chk(h2 == cur.br, "R3", "branch fetched two slots earlier", h2, cur.br);
                    chk(link_valid == cur.link, "R11", "link strobe", AW'(link_valid), AW'(cur.link));
                    if (cur.link)
                        chk(link_addr == cur.laddr, "R11", "link address", link_addr, cur.laddr);
                end
                chk(!fetch_req, "R3", "fetch during redirect", AW'(fetch_req), '0);
                chk(id_valid, "R4", "delay slot held in decode", AW'(id_valid), 1);
                chk(!redirect_addr[0], "R10", "target bit 0", redirect_addr, redirect_addr & ~AW'(1));
            end
            chk(id_stall == redirect, "R5", "stall only in redirect slot", AW'(id_stall), AW'(redirect));
            if (pr_red) begin
                chk(fetch_req && fetch_addr == pr_raddr, "R6", "target fetch", fetch_addr, pr_raddr);
                chk(!ex_valid, "R4", "bubble in execute", AW'(ex_valid), '0);
            end
            if (pr2_red)
                chk(ex_valid, "R4", "delay slot executes", AW'(ex_valid), 1);
            if (!redirect)
                chk(fetch_req, "R2", "fetch request outside redirect", AW'(fetch_req), 1);
            if (pr_freq && !pr_red && fetch_req)
                chk(fetch_addr == pr_faddr + 2, "R2", "sequential address", fetch_addr, pr_faddr + 2);
            if (illegal_slot) begin
                n_ill++;
                chk(!redirect && !link_valid, "R12", "quiet illegal slot",
                    AW'({redirect, link_valid}), '0);
            end
            if (link_valid && !redirect)
                chk(0, "R11", "link outside redirect", AW'(link_valid), '0);
            pr2_red  = pr_red;
            pr_red   = redirect;
            pr_raddr = redirect_addr;
            pr_freq  = fetch_req;
            pr_faddr = fetch_addr;
            h2       = h1;
            h1       = fetch_addr;
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        chk(0, "R3", "watchdog expired", '0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) imem[i] = 16'h0000;
        for (int i = 0; i < 16; i++) regs[i] = '0;
        imem[8'h12 >> 1] = 16'hA005;  // R7 forward relative jump
        imem[8'h20 >> 1] = 16'hBFFC;  // R7 backward relative call
        imem[8'h1C >> 1] = 16'h8200;  // R8 pc+reg jump, r2
        imem[8'h2A >> 1] = 16'h8303;  // R9 absolute call, r3
        imem[8'h2C >> 1] = 16'hA010;  // R12 branch in delay slot
        imem[8'h40 >> 1] = 16'h8401;  // R8 pc+reg call, r4
        imem[8'h64 >> 1] = 16'h8504;  // R9 return, r5
        imem[8'h80 >> 1] = 16'h8602;  // R9 absolute jump, r6
        regs[2] = 32'h0A;
        regs[3] = 32'h41;             // R10 odd value is aligned
        regs[4] = 32'h20;
        regs[5] = 32'h80;
        regs[6] = 32'h90;

        push_exp(32'h12, 32'h20, 0, "R7");
        push_exp(32'h20, 32'h1C, 1, "R7");
        push_exp(32'h1C, 32'h2A, 0, "R8");
        push_exp(32'h2A, 32'h40, 1, "R9");
        push_exp(32'h40, 32'h64, 1, "R8");
        push_exp(32'h64, 32'h80, 0, "R9");
        push_exp(32'h80, 32'h90, 0, "R9");

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!if_valid && !id_valid && !ex_valid, "R1", "valids in reset",
            AW'({if_valid, id_valid, ex_valid}), '0);
        chk(!fetch_req && !id_stall && !redirect, "R1", "controls in reset",
            AW'({fetch_req, id_stall, redirect}), '0);
        rst = 1'b0;
        #1;
        chk(fetch_req && fetch_addr == 32'h10, "R1", "first fetch at vector", fetch_addr, 32'h10);
        mon_on = 1'b1;

        wait (exp_q.size() == 0);
        repeat (6) @(negedge clk);
        mon_on = 1'b0;
        chk(n_red == 7, "R3", "redirect count", AW'(n_red), 7);
        chk(n_ill == 1, "R12", "illegal slot pulses", AW'(n_ill), 1);

        reset_vec = 32'h30;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(!if_valid && !id_valid && !ex_valid, "R1", "valids cleared mid-run",
            AW'({if_valid, id_valid, ex_valid}), '0);
        chk(!id_stall && !redirect && !fetch_req, "R1", "controls cleared mid-run",
            AW'({id_stall, redirect, fetch_req}), '0);
        rst = 1'b0;
        #1;
        chk(fetch_req && fetch_addr == 32'h30, "R1", "restart at new vector", fetch_addr, 32'h30);
        repeat (3) @(negedge clk);
        chk(id_valid && ex_valid, "R2", "pipeline refills", AW'({id_valid, ex_valid}), 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule